// File: doc/BRIEF.md
# Priority Shared Memory Bus Arbiter

This block shares one narrow asynchronous memory bus, carrying a boot ROM, an EEPROM and an SRAM, between a small processor and a set of DMA clients. The processor always wins. The clients only use the idle gaps between processor accesses. If the processor asks for the bus while a client byte is still in flight, it is held with a wait signal until that one transfer has finished.

A page register sits on two processor I/O ports. It supplies the upper bits of a 29-bit physical address whenever the processor touches the top quarter of its 16-bit space. The resulting physical address is decoded into the three chip selects, and addresses outside all three regions select no device. Among the clients, priority is fixed by index. The last client (bulk storage) can be throttled: after each of its transfers it is held off for a programmable number of cycles, which bounds its share of the bus.

Top module: `membus_arbiter`

## Requirements
- R1: After reset the bus is idle. No chip select, read strobe, write strobe, grant or wait is asserted, `mem_addr` is zero, and the page register holds zero.
- R2: In a cycle where the bus is idle and `cpu_mreq` is high, the processor wins the next transfer, even when client requests are pending.
- R3: A client transfer never starts out of an idle cycle in which `cpu_mreq` is high. While the processor holds `cpu_mreq` high across back-to-back accesses, no client is granted. Once `cpu_mreq` drops, a pending client is served.
- R4: `cpu_wait` is high only while a client owns the bus and `cpu_mreq` is high. It never stays high for more than XFER_CYC (default 3) consecutive cycles.
- R5: Among clients that request in the same idle cycle, the lowest index wins (0 command, 1 telemetry, 2 instrument, 3 bulk storage). At most one grant is high at a time.
- R6: Every transfer lasts exactly XFER_CYC cycles, with `mem_oe` (read) or `mem_we` (write) high throughout. `cpu_done` or the client's `cli_done` bit is high in the last cycle. A processor access started on an idle bus completes XFER_CYC cycles after the request is first seen.
- R7: Processor addresses 0x0000–0x7FFF map to physical 0x00000–0x07FFF. Addresses 0x8000–0xBFFF map to physical 0x40000 + addr[13:0].
- R8: Processor addresses 0xC000–0xFFFF map to physical {page[14:0], addr[13:0]}. The physical decode is as follows. Below 0x08000 selects ROM (`cs_rom`). 0x20000–0x3FFFF selects EEPROM (`cs_eep`). 0x40000–0x5FFFF selects SRAM (`cs_sram`). Anything else selects nothing. `mem_addr` is physical bits [16:0], and `bus_rdata` reads 0xFF when no select is active.
- R9: An I/O write to port PAGE_PORT (default 0x40) loads page[7:0] from `cpu_wdata`. A write to PAGE_PORT+1 loads page[14:8] from `cpu_wdata[6:0]`. Writes to any other port leave the page unchanged.
- R10: With `thr_en` high, after client 3's transfer ends in cycle D, its next grant rises no earlier than cycle D+`thr_gap`+2. With a sole requester, it rises exactly then.
- R11: With `thr_en` low, client 3 is re-granted in cycle D+2 after its transfer ends in cycle D, the same as any other client.
- R12: A client transfer drives `cs_sram`, `mem_addr` = its 17-bit `cli_addr` field, and, for a write, `mem_wdata` = its `cli_wdata` byte with `mem_we`. A client read returns the SRAM byte on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_mreq | input | 1 | Processor memory request, held until `cpu_done` |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_addr | input | 16 | Processor logical address |
| cpu_wdata | input | 8 | Processor write data, also the I/O write data |
| cpu_io_wr | input | 1 | Processor I/O write strobe |
| cpu_io_addr | input | 8 | Processor I/O port number |
| cpu_wait | output | 1 | Processor stall while a client transfer finishes |
| cpu_done | output | 1 | Last cycle of a processor transfer |
| cli_req | input | 4 | Client requests, held until that client's done |
| cli_we | input | 4 | Client write flags |
| cli_addr | input | 68 | Client SRAM addresses, 17 bits per client |
| cli_wdata | input | 32 | Client write bytes, 8 bits per client |
| cli_gnt | output | 4 | Client owns the bus |
| cli_done | output | 4 | Last cycle of a client transfer |
| thr_en | input | 1 | Enable the client-3 throttle |
| thr_gap | input | 8 | Hold-off cycles after each client-3 transfer |
| mem_addr | output | 17 | Memory bus address |
| mem_wdata | output | 8 | Memory bus write data |
| mem_rdata | input | 8 | Memory bus read data |
| mem_oe | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| cs_rom | output | 1 | ROM select |
| cs_eep | output | 1 | EEPROM select |
| cs_sram | output | 1 | SRAM select |
| bus_rdata | output | 8 | Read byte returned to the current master |

## Verification
The address map is walked with a vector table of processor reads and writes across both unpaged halves. The table also drives paged accesses whose page values land in each device, in the gap between devices, and at the top of the 29-bit space. The returned byte is an address hash keyed per device, so a wrong select, a wrong offset and a missing page bit each show up differently. Arbitration is tried with four simultaneous client requests, which separates fixed priority from round-robin. It is also tried with a processor request arriving together with a client request, which separates processor priority from first-come service. A request arriving in mid client transfer measures the stall length, and a held processor request shows whether clients slip in between back-to-back accesses. The throttle is timed with the gap both enabled and disabled, so a hold-off that is off by one cycle is visible.

// File: rtl/mb_pkg.sv
package mb_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_CPU  = 2'd1,
      OWN_CLI  = 2'd2
   } mb_owner_e;

   typedef struct packed {
      logic rom;
      logic eep;
      logic sram;
   } mb_sel_t;

   localparam mb_sel_t SEL_NONE = '{rom: 1'b0, eep: 1'b0, sram: 1'b0};
   localparam mb_sel_t SEL_SRAM = '{rom: 1'b0, eep: 1'b0, sram: 1'b1};
endpackage

// File: rtl/mb_page_map.sv
module mb_page_map
   import mb_pkg::*;
#(
   parameter int CPU_AW    = 16,
   parameter int PHYS_W    = 29,
   parameter int BUS_AW    = 17,
   parameter int IO_AW     = 8,
   parameter int DW        = 8,
   parameter int ROM_AW    = 15,
   parameter int RAM_AW    = 17,
   parameter logic [IO_AW-1:0]  PAGE_PORT = 'h40,
   parameter logic [PHYS_W-1:0] EEP_BASE  = 'h20000,
   parameter logic [PHYS_W-1:0] SRAM_BASE = 'h40000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [IO_AW-1:0]  io_addr,
   input  logic [DW-1:0]     io_wdata,
   input  logic [CPU_AW-1:0] cpu_addr,
   output logic [BUS_AW-1:0] bus_addr,
   output mb_sel_t           sel
);
   localparam int WIN_W      = CPU_AW - 2;
   localparam int PAGE_W     = PHYS_W - WIN_W;
   localparam int PAGE_BYTES = (PAGE_W + DW - 1) / DW;

   if (PAGE_W < 1 || BUS_AW > PHYS_W || ROM_AW > BUS_AW || RAM_AW > BUS_AW) begin : g_bad_map
      $error("mb_page_map: inconsistent address widths");
   end

   logic [PAGE_W-1:0] page_q;
   logic [PHYS_W-1:0] phys;

   for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_page_byte
      localparam int BW = (PAGE_W - b*DW > DW) ? DW : PAGE_W - b*DW;
      localparam logic [IO_AW-1:0] PORT = PAGE_PORT + IO_AW'(b);
      always_ff @(posedge clk) begin
         if (!rst_n)
            page_q[b*DW +: BW] <= '0;
         else if (io_wr && io_addr == PORT)
            page_q[b*DW +: BW] <= io_wdata[BW-1:0];
      end
   end

   always_comb begin
      if (cpu_addr[CPU_AW-1 -: 2] == 2'b11)
         phys = {page_q, cpu_addr[WIN_W-1:0]};
      else if (!cpu_addr[CPU_AW-1])
         phys = PHYS_W'(cpu_addr[CPU_AW-2:0]);
      else
         phys = SRAM_BASE | PHYS_W'(cpu_addr[WIN_W-1:0]);
   end

   always_comb begin
      sel      = SEL_NONE;
      sel.rom  = (phys[PHYS_W-1:ROM_AW] == '0);
      sel.eep  = (phys[PHYS_W-1:RAM_AW] == EEP_BASE[PHYS_W-1:RAM_AW]);
      sel.sram = (phys[PHYS_W-1:RAM_AW] == SRAM_BASE[PHYS_W-1:RAM_AW]);
      bus_addr = phys[BUS_AW-1:0];
   end
endmodule

// File: rtl/mb_pick.sv
module mb_pick #(
   parameter int N_CLI   = 4,
   parameter int THR_IDX = 3,
   parameter bit HAS_THR = 1'b1,
   localparam int IDX_W  = $clog2(N_CLI)
) (
   input  logic [N_CLI-1:0] req,
   input  logic             thr_block,
   output logic             pick_vld,
   output logic [IDX_W-1:0] pick_idx
);
   logic [N_CLI-1:0] elig;

   for (genvar i = 0; i < N_CLI; i++) begin : g_elig
      if (HAS_THR && i == THR_IDX) begin : g_gated
         assign elig[i] = req[i] & ~thr_block;
      end else begin : g_plain
         assign elig[i] = req[i];
      end
   end

   always_comb begin
      pick_vld = |elig;
      pick_idx = '0;
      for (int i = N_CLI-1; i >= 0; i--)
         if (elig[i]) pick_idx = IDX_W'(i);
   end
endmodule

// File: rtl/mb_throttle.sv
module mb_throttle #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [THR_W-1:0] gap,
   input  logic             load,
   output logic             block
);
   logic [THR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load && en)
         cnt_q <= gap;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign block = en && (cnt_q != '0);
endmodule

// File: rtl/membus_arbiter.sv
module membus_arbiter
   import mb_pkg::*;
#(
   parameter int N_CLI    = 4,
   parameter int CPU_AW   = 16,
   parameter int PHYS_W   = 29,
   parameter int BUS_AW   = 17,
   parameter int DW       = 8,
   parameter int IO_AW    = 8,
   parameter int XFER_CYC = 3,
   parameter int THR_W    = 8,
   parameter int THR_IDX  = 3,
   parameter bit HAS_THR  = 1'b1,
   parameter logic [IO_AW-1:0] PAGE_PORT = 'h40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_mreq,
   input  logic                    cpu_wr,
   input  logic [CPU_AW-1:0]       cpu_addr,
   input  logic [DW-1:0]           cpu_wdata,
   input  logic                    cpu_io_wr,
   input  logic [IO_AW-1:0]        cpu_io_addr,
   output logic                    cpu_wait,
   output logic                    cpu_done,
   input  logic [N_CLI-1:0]        cli_req,
   input  logic [N_CLI-1:0]        cli_we,
   input  logic [N_CLI*BUS_AW-1:0] cli_addr,
   input  logic [N_CLI*DW-1:0]     cli_wdata,
   output logic [N_CLI-1:0]        cli_gnt,
   output logic [N_CLI-1:0]        cli_done,
   input  logic                    thr_en,
   input  logic [THR_W-1:0]        thr_gap,
   output logic [BUS_AW-1:0]       mem_addr,
   output logic [DW-1:0]           mem_wdata,
   input  logic [DW-1:0]           mem_rdata,
   output logic                    mem_oe,
   output logic                    mem_we,
   output logic                    cs_rom,
   output logic                    cs_eep,
   output logic                    cs_sram,
   output logic [DW-1:0]           bus_rdata
);
   localparam int IDX_W = $clog2(N_CLI);
   localparam int CNT_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;

   if (N_CLI < 2 || THR_IDX >= N_CLI || XFER_CYC < 1) begin : g_bad_cfg
      $error("membus_arbiter: bad client count, throttle index or transfer length");
   end

   mb_owner_e         owner_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic              we_q;
   logic [BUS_AW-1:0] addr_q;
   logic [DW-1:0]     wdata_q;
   mb_sel_t           sel_q;

   logic [BUS_AW-1:0] map_addr;
   mb_sel_t           map_sel;
   logic              pick_vld;
   logic [IDX_W-1:0]  pick_idx;
   logic              thr_block;
   logic              last_cyc;
   logic              bus_busy;
   logic              own_cpu;
   logic              own_cli;

   mb_page_map #(
      .CPU_AW(CPU_AW), .PHYS_W(PHYS_W), .BUS_AW(BUS_AW), .IO_AW(IO_AW),
      .DW(DW), .PAGE_PORT(PAGE_PORT)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .io_wr(cpu_io_wr), .io_addr(cpu_io_addr),
      .io_wdata(cpu_wdata), .cpu_addr(cpu_addr), .bus_addr(map_addr), .sel(map_sel)
   );

   mb_pick #(.N_CLI(N_CLI), .THR_IDX(THR_IDX), .HAS_THR(HAS_THR)) u_pick (
      .req(cli_req), .thr_block(thr_block), .pick_vld(pick_vld), .pick_idx(pick_idx)
   );

   if (HAS_THR) begin : g_thr
      mb_throttle #(.THR_W(THR_W)) u_thr (
         .clk(clk), .rst_n(rst_n), .en(thr_en), .gap(thr_gap),
         .load(cli_done[THR_IDX]), .block(thr_block)
      );
   end else begin : g_nothr
      assign thr_block = 1'b0;
   end

   assign bus_busy = (owner_q != OWN_IDLE);
   assign own_cpu  = (owner_q == OWN_CPU);
   assign own_cli  = (owner_q == OWN_CLI);
   assign last_cyc = bus_busy && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_q <= OWN_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         sel_q   <= SEL_NONE;
      end else if (!bus_busy) begin
         if (cpu_mreq) begin
            owner_q <= OWN_CPU;
            cnt_q   <= CNT_W'(XFER_CYC - 1);
            we_q    <= cpu_wr;
            addr_q  <= map_addr;
            wdata_q <= cpu_wdata;
            sel_q   <= map_sel;
         end else if (pick_vld) begin
            owner_q <= OWN_CLI;
            cnt_q   <= CNT_W'(XFER_CYC - 1);
            idx_q   <= pick_idx;
            we_q    <= cli_we[pick_idx];
            addr_q  <= cli_addr[pick_idx*BUS_AW +: BUS_AW];
            wdata_q <= cli_wdata[pick_idx*DW +: DW];
            sel_q   <= SEL_SRAM;
         end
      end else if (last_cyc) begin
         owner_q <= OWN_IDLE;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   for (genvar i = 0; i < N_CLI; i++) begin : g_cli_out
      assign cli_gnt[i]  = own_cli && (idx_q == IDX_W'(i));
      assign cli_done[i] = cli_gnt[i] && last_cyc;
   end

   assign cpu_done  = own_cpu && last_cyc;
   assign cpu_wait  = cpu_mreq && own_cli;
   assign mem_oe    = bus_busy && !we_q;
   assign mem_we    = bus_busy && we_q;
   assign mem_addr  = bus_busy ? addr_q : '0;
   assign mem_wdata = bus_busy ? wdata_q : '0;
   assign cs_rom    = bus_busy && sel_q.rom;
   assign cs_eep    = bus_busy && sel_q.eep;
   assign cs_sram   = bus_busy && sel_q.sram;
   assign bus_rdata = (cs_rom || cs_eep || cs_sram) ? mem_rdata : '1;
endmodule

// File: rtl/mb_arbiter_chk.sv
module mb_arbiter_chk #(
   parameter int N_CLI    = 4,
   parameter int XFER_CYC = 3,
   parameter int THR_W    = 8,
   parameter int THR_IDX  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_mreq,
   input logic             cpu_wait,
   input logic             cpu_done,
   input logic [N_CLI-1:0] cli_gnt,
   input logic [N_CLI-1:0] cli_done,
   input logic             cs_rom,
   input logic             cs_eep,
   input logic             cs_sram,
   input logic             thr_en,
   input logic [THR_W-1:0] thr_gap,
   input logic             bus_busy,
   input logic             own_cpu,
   input logic             own_cli
);
   logic [15:0]      wait_run;
   logic [15:0]      busy_len;
   logic [THR_W-1:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_run <= '0;
         busy_len <= '0;
         gap_cnt  <= '0;
      end else begin
         wait_run <= cpu_wait ? wait_run + 16'd1 : '0;
         busy_len <= (bus_busy && !(cpu_done || |cli_done)) ? busy_len + 16'd1 : '0;
         if (cli_done[THR_IDX])
            gap_cnt <= thr_en ? thr_gap : '0;
         else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - 1'b1;
      end
   end

   a_r2_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_busy && cpu_mreq) |=> own_cpu);

   a_r3_no_client_in_cpu_req: assert property (@(posedge clk) disable iff (!rst_n)
      (own_cli && !$past(own_cli)) |-> !$past(cpu_mreq));

   a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> (wait_run < 16'(XFER_CYC)));

   a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cli_gnt) && !(own_cpu && |cli_gnt));

   a_r6_xfer_len: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done || |cli_done) |-> (busy_len == 16'(XFER_CYC - 1)));

   a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_rom, cs_eep, cs_sram}) && (bus_busy || !(cs_rom || cs_eep || cs_sram)));

   a_r10_throttle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cli_gnt[THR_IDX]) && thr_en) |-> ($past(gap_cnt) == '0));
endmodule

bind membus_arbiter mb_arbiter_chk #(
   .N_CLI(N_CLI), .XFER_CYC(XFER_CYC), .THR_W(THR_W), .THR_IDX(THR_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_mreq(cpu_mreq), .cpu_wait(cpu_wait),
   .cpu_done(cpu_done), .cli_gnt(cli_gnt), .cli_done(cli_done),
   .cs_rom(cs_rom), .cs_eep(cs_eep), .cs_sram(cs_sram),
   .thr_en(thr_en), .thr_gap(thr_gap), .bus_busy(bus_busy),
   .own_cpu(own_cpu), .own_cli(own_cli)
);

// File: tb/sim_membus_arbiter.sv
`timescale 1ns/1ps
module sim_membus_arbiter;
   localparam int XF = 3;
   localparam logic [7:0] PORT = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_mreq = 1'b0, cpu_wr = 1'b0, cpu_io_wr = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0, cpu_io_addr = '0;
   logic        cpu_wait, cpu_done;
   logic [3:0]  cli_req = '0, cli_we = '0;
   logic [67:0] cli_addr = '0;
   logic [31:0] cli_wdata = '0;
   logic [3:0]  cli_gnt, cli_done;
   logic        thr_en = 1'b0;
   logic [7:0]  thr_gap = 8'd10;
   logic [16:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata, bus_rdata;
   logic        mem_oe, mem_we, cs_rom, cs_eep, cs_sram;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   assign mem_rdata = cs_rom  ? (mem_addr[7:0] ^ 8'hA5) :
                      cs_eep  ? (mem_addr[7:0] ^ 8'h3C) :
                      cs_sram ? (mem_addr[7:0] ^ 8'h5A) : 8'h00;

   membus_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .cpu_mreq(cpu_mreq), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_io_wr(cpu_io_wr),
      .cpu_io_addr(cpu_io_addr), .cpu_wait(cpu_wait), .cpu_done(cpu_done),
      .cli_req(cli_req), .cli_we(cli_we), .cli_addr(cli_addr), .cli_wdata(cli_wdata),
      .cli_gnt(cli_gnt), .cli_done(cli_done), .thr_en(thr_en), .thr_gap(thr_gap),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_oe(mem_oe), .mem_we(mem_we), .cs_rom(cs_rom), .cs_eep(cs_eep),
      .cs_sram(cs_sram), .bus_rdata(bus_rdata)
   );

   typedef struct packed {
      logic [14:0] page;
      logic [15:0] addr;
      logic        we;
      logic [7:0]  wd;
      logic [16:0] exp_a;
      logic [2:0]  exp_cs;   // {rom, eep, sram}
      logic [7:0]  exp_d;    // read: bus_rdata; write: mem_wdata
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{15'h0000, 16'h0123, 1'b0, 8'h00, 17'h00123, 3'b100, 8'h86},
      '{15'h0000, 16'h7FFF, 1'b0, 8'h00, 17'h07FFF, 3'b100, 8'h5A},
      '{15'h0000, 16'h8010, 1'b0, 8'h00, 17'h00010, 3'b001, 8'h4A},
      '{15'h0000, 16'hBFFF, 1'b1, 8'h77, 17'h03FFF, 3'b001, 8'h77},
      '{15'h0008, 16'hC005, 1'b0, 8'h00, 17'h00005, 3'b010, 8'h39},
      '{15'h000F, 16'hFFFF, 1'b0, 8'h00, 17'h1FFFF, 3'b010, 8'hC3},
      '{15'h0010, 16'hC100, 1'b0, 8'h00, 17'h00100, 3'b001, 8'h5A},
      '{15'h0001, 16'hC200, 1'b0, 8'h00, 17'h04200, 3'b100, 8'hA5},
      '{15'h0002, 16'hC000, 1'b0, 8'h00, 17'h08000, 3'b000, 8'hFF},
      '{15'h7FFF, 16'hD234, 1'b0, 8'h00, 17'h1D234, 3'b000, 8'hFF},
      '{15'h0011, 16'hE0AB, 1'b1, 8'h3E, 17'h060AB, 3'b001, 8'h3E}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [7:0] port, input logic [7:0] d);
      @(negedge clk);
      cpu_io_wr = 1'b1; cpu_io_addr = port; cpu_wdata = d;
      @(negedge clk);
      cpu_io_wr = 1'b0;
   endtask

   task automatic set_page(input logic [14:0] p);
      io_write(PORT, p[7:0]);
      io_write(PORT + 8'd1, {1'b0, p[14:8]});
   endtask

   task automatic cpu_acc(input logic we, input logic [15:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output logic [16:0] ma,
                          output logic [2:0] cs, output logic [7:0] wo,
                          output logic stb, output int lat);
      @(negedge clk);
      cpu_mreq = 1'b1; cpu_wr = we; cpu_addr = a; cpu_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!cpu_done && lat < 50);
      rd = bus_rdata; ma = mem_addr; cs = {cs_rom, cs_eep, cs_sram};
      wo = mem_wdata; stb = we ? (mem_we && !mem_oe) : (mem_oe && !mem_we);
      cpu_mreq = 1'b0; cpu_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd, wo;
      logic [16:0] ma;
      logic [2:0] cs;
      logic stb;
      int lat;
      int order [4];
      int nd;
      int waits;
      int gcnt;
      int t, t_done, gap;
      logic prev_g;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 idle outputs", {mem_oe, mem_we, cs_rom, cs_eep, cs_sram, cpu_wait, cpu_done},
            7'b0);
      check("R1 grants", {cli_gnt, cli_done}, 8'h00);
      check("R1 mem_addr", mem_addr, 17'h0);
      cpu_acc(1'b0, 16'hC005, 8'h00, rd, ma, cs, wo, stb, lat);
      check("R1 page reset to zero", {cs, ma}, {3'b100, 17'h00005});

      // Vector table: address map, paging, page ports, transfer length
      for (int v = 0; v < NV; v++) begin
         set_page(VEC[v].page);
         cpu_acc(VEC[v].we, VEC[v].addr, VEC[v].wd, rd, ma, cs, wo, stb, lat);
         if (VEC[v].addr[15:14] == 2'b11) begin
            check("R8 R9 paged addr", ma, VEC[v].exp_a);
            check("R8 paged select", cs, VEC[v].exp_cs);
         end else begin
            check("R7 unpaged addr", ma, VEC[v].exp_a);
            check("R7 unpaged select", cs, VEC[v].exp_cs);
         end
         check("R8 data", VEC[v].we ? wo : rd, VEC[v].exp_d);
         check("R6 latency", lat, XF);
         check("R6 strobe", stb, 1'b1);
      end

      // R9: other ports ignored
      set_page(15'h0008);
      io_write(PORT + 8'd2, 8'h55);
      io_write(PORT - 8'd1, 8'h66);
      cpu_acc(1'b0, 16'hC005, 8'h00, rd, ma, cs, wo, stb, lat);
      check("R9 foreign port ignored", {cs, ma}, {3'b010, 17'h00005});

      // R5: fixed client priority
      cli_addr = {17'h00033, 17'h00022, 17'h00011, 17'h00044};
      cli_we = 4'b0000;
      @(negedge clk);
      cli_req = 4'b1111;
      nd = 0;
      for (int k = 0; k < 60 && nd < 4; k++) begin
         @(negedge clk);
         for (int i = 0; i < 4; i++)
            if (cli_done[i]) begin
               order[nd] = i; nd++; cli_req[i] = 1'b0;
               if (i == 0) check("R12 client read data", bus_rdata, 8'h44 ^ 8'h5A);
            end
      end
      check("R5 count", nd, 4);
      check("R5 order", {order[0][3:0], order[1][3:0], order[2][3:0], order[3][3:0]}, 16'h0123);

      // R12: client write
      cli_addr[16:0] = 17'h00ABC; cli_wdata[7:0] = 8'hD2; cli_we = 4'b0001;
      @(negedge clk);
      cli_req[0] = 1'b1;
      do @(negedge clk); while (!cli_done[0]);
      check("R12 client write", {cs_rom, cs_eep, cs_sram, mem_we, mem_addr, mem_wdata},
            {3'b001, 1'b1, 17'h00ABC, 8'hD2});
      cli_req[0] = 1'b0; cli_we = 4'b0000;

      // R2: simultaneous CPU and client request on an idle bus
      @(negedge clk);
      cpu_mreq = 1'b1; cpu_addr = 16'h0001; cli_req[1] = 1'b1;
      @(negedge clk);
      check("R2 cpu wins", {cli_gnt, cpu_wait}, 5'b0);
      // R3: CPU holding request back-to-back starves clients
      gcnt = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (|cli_gnt) gcnt++;
      end
      check("R3 no client while cpu_mreq", gcnt, 0);
      wait (cpu_done == 1'b1);
      @(negedge clk);
      cpu_mreq = 1'b0;
      gcnt = 0;
      for (int k = 0; k < 10 && gcnt == 0; k++) begin
         @(negedge clk);
         if (cli_gnt[1]) gcnt++;
      end
      check("R3 client served in gap", gcnt, 1);
      do @(negedge clk); while (!cli_done[1]);
      cli_req[1] = 1'b0;

      // R4: CPU request arriving during a client transfer
      @(negedge clk);
      cli_req[2] = 1'b1;
      do @(negedge clk); while (!cli_gnt[2]);
      cpu_mreq = 1'b1; cpu_addr = 16'h8010;
      #1;
      waits = cpu_wait ? 1 : 0;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         if (cli_done[2]) cli_req[2] = 1'b0;
         if (cpu_wait) waits++;
      end while (!cpu_done && lat < 50);
      check("R4 wait length", waits, XF);
      check("R4 cpu data after wait", bus_rdata, 8'h4A);
      cpu_mreq = 1'b0;

      // R10: throttle gap for client 3
      for (int pass = 0; pass < 2; pass++) begin
         repeat (3) @(negedge clk);
         thr_en = (pass == 0);
         cli_req[3] = 1'b1;
         t = 0; t_done = -1; gap = -1; prev_g = 1'b0;
         for (int k = 0; k < 200 && gap < 0; k++) begin
            @(negedge clk);
            t++;
            if (cli_gnt[3] && !prev_g && t_done >= 0) gap = t - t_done;
            if (cli_done[3]) t_done = t;
            prev_g = cli_gnt[3];
         end
         if (pass == 0) check("R10 throttled regrant", gap, 32'(thr_gap) + 2);
         else           check("R11 unthrottled regrant", gap, 2);
         cli_req[3] = 1'b0;
         repeat (6) @(negedge clk);
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule